// File: doc/BRIEF.md
# Free-Running 64-Bit Timebase

This block is a 64-bit up-counter meant to serve as the system time source. It sits behind a plain 32-bit register bus with single-cycle, unacknowledged accesses. Software can preload either 32-bit half of the count, start or halt counting through a control register, and read the count back as two halves. The count advances by one on every clock edge where the `tick_en` pulse is high and the counter is running. A separate prescaler produces `tick_en`.

Writes to the two count halves and to the control register are not applied at once. Each one is captured into a delay line and takes effect `APPLY_DLY` clock edges after the bus accepted it. On that same edge a matching sticky status bit is set. Software polls this bit to learn that its write has landed, then clears it by writing 1 to it. Status writes themselves act on the edge that accepts them.

Run control is a two-state machine. `ST_HALT` is the reset state and does not count. `ST_RUN` counts enabled ticks. The transition `GO` (`ST_HALT` to `ST_RUN`) fires when a control write with run bit 8 set is applied. The transition `STOP` (`ST_RUN` to `ST_HALT`) fires when a control write with bit 8 clear is applied. Any other applied control write keeps the current state.

The read path always shows the live count. Software reads upper, then lower, then upper again, and retries if the two upper values differ. This gives a coherent 64-bit value.

Top module: `ftb_timebase`

## Requirements
- R1: After reset, every mapped register reads 0, the machine is in `ST_HALT`, and no write is pending.
- R2: While `bus_req`=1 and `bus_we`=0, `bus_rdata` returns the following: at offset 0x100 the count bits 31:0; at 0x104 the count bits 63:32; at 0x110 the count write-status in bits 1:0 with zeros above; at 0x240 the run state in bit 8 with zeros elsewhere; at 0x24C the control write-status in bit 16 with zeros elsewhere. Any other offset reads 0, and `bus_rdata` is 0 when no read is requested.
- R3: A write to 0x100 (or 0x104) replaces only the low (or high) half of the count. It takes effect on the `APPLY_DLY`-th rising edge after the edge that accepted the write. The count is unchanged before that edge.
- R4: A control write at 0x240 is applied after the same delay. Bit 8 = 1 takes `GO`; bit 8 = 0 takes `STOP`. The other written bits are ignored. Counting begins on the edge after `GO` is applied.
- R5: In `ST_RUN` the count rises by exactly 1 on each edge with `tick_en`=1. It holds when `tick_en`=0 and at every edge in `ST_HALT`.
- R6: The count wraps from all ones to zero, and a carry out of the low half increments the high half on the same edge.
- R7: On an edge where a preload is applied, the preloaded half takes the written data, the other half holds, and no increment happens, even with `tick_en`=1 in `ST_RUN`.
- R8: The edge that applies a low-half write sets bit 0 of 0x110. A high-half write sets bit 1 of 0x110. A control write sets bit 16 of 0x24C.
- R9: Status bits stay set until a write places 1 in that bit position of their register. Writing 0 leaves them unchanged. If a set and a clear reach the same bit on the same edge, the bit ends set.
- R10: Writes to unmapped offsets change no count, run state or status bit.
- R11: Writes on consecutive cycles are each applied, in order, `APPLY_DLY` edges after their own acceptance.
- R12: A reader that follows the upper/lower/upper retry sequence gets a 64-bit value equal to the count at the moment of the lower read, including across a low-half carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count-enable pulse from the prescaler |
| bus_req | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |

## Verification
Two collisions on the same edge are the ones that matter. The first is a delayed preload landing while the counter is running with `tick_en` high. The second is a status bit being set by an applied write while software is clearing it. The bench provokes the first by preloading with ticks held high in `ST_RUN`. It provokes the second by issuing the write-1-to-clear exactly `APPLY_DLY` cycles after the write it acknowledges. A behavioural model keeps pending writes in a queue keyed by their due cycle and judges every read cycle against the block. The model applies clears before sets, and lets a preload displace the increment.

// File: rtl/ftb_pkg.sv
package ftb_pkg;

    localparam int unsigned FTB_DW = 32;
    localparam int unsigned FTB_CW = 2 * FTB_DW;

    // register offsets; the status bit positions are polled by software
    localparam logic [11:0] OFS_CNT_LO   = 12'h100;
    localparam logic [11:0] OFS_CNT_HI   = 12'h104;
    localparam logic [11:0] OFS_CNT_WST  = 12'h110;
    localparam logic [11:0] OFS_CTRL     = 12'h240;
    localparam logic [11:0] OFS_CTRL_WST = 12'h24C;

    localparam int unsigned RUN_BIT      = 8;
    localparam int unsigned CTRL_WST_BIT = 16;

    typedef enum logic [1:0] {
        TGT_LO   = 2'd0,
        TGT_HI   = 2'd1,
        TGT_CTRL = 2'd2
    } wr_tgt_e;

    typedef struct packed {
        logic              vld;
        wr_tgt_e           tgt;
        logic [FTB_DW-1:0] data;
    } wr_rec_t;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_st_e;

endpackage

// File: rtl/ftb_apply_pipe.sv
module ftb_apply_pipe
    import ftb_pkg::*;
#(
    parameter int unsigned DEPTH = 3
) (
    input  logic    clk,
    input  logic    rst_n,
    input  wr_rec_t in_rec,
    output wr_rec_t out_rec
);

    wr_rec_t [DEPTH-1:0] stg_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg_q <= '0;
                end else begin
                    stg_q[0] <= in_rec;
                end
            end
        end else begin : g_shift
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg_q <= '0;
                end else begin
                    stg_q <= {stg_q[DEPTH-2:0], in_rec};
                end
            end
        end
    endgenerate

    assign out_rec = stg_q[DEPTH-1];

endmodule

// File: rtl/ftb_count_core.sv
module ftb_count_core
    import ftb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  wr_rec_t           app_rec,
    output logic [FTB_CW-1:0] count,
    output logic              running
);

    run_st_e           st_q;
    run_st_e           st_d;
    logic [FTB_CW-1:0] cnt_q;
    logic              ctrl_hit;
    logic              pre_lo;
    logic              pre_hi;

    assign ctrl_hit = app_rec.vld && (app_rec.tgt == TGT_CTRL);
    assign pre_lo   = app_rec.vld && (app_rec.tgt == TGT_LO);
    assign pre_hi   = app_rec.vld && (app_rec.tgt == TGT_HI);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_HALT;
        end else begin
            st_q <= st_d;
        end
    end

    // next-state: GO and STOP transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HALT: if (ctrl_hit &&  app_rec.data[RUN_BIT]) st_d = ST_RUN;
            ST_RUN:  if (ctrl_hit && !app_rec.data[RUN_BIT]) st_d = ST_HALT;
        endcase
    end

    // count datapath: preload outranks increment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (pre_lo) begin
            cnt_q[FTB_DW-1:0] <= app_rec.data;
        end else if (pre_hi) begin
            cnt_q[FTB_CW-1:FTB_DW] <= app_rec.data;
        end else if ((st_q == ST_RUN) && tick_en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        count   = cnt_q;
        running = (st_q == ST_RUN);
    end

endmodule

// File: rtl/ftb_status.sv
module ftb_status
    import ftb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  wr_rec_t    app_rec,
    input  logic [1:0] clr_cnt,
    input  logic       clr_ctrl,
    output logic [1:0] sts_cnt,
    output logic       sts_ctrl
);

    logic [1:0] set_cnt;
    logic       set_ctrl;

    assign set_cnt[0] = app_rec.vld && (app_rec.tgt == TGT_LO);
    assign set_cnt[1] = app_rec.vld && (app_rec.tgt == TGT_HI);
    assign set_ctrl   = app_rec.vld && (app_rec.tgt == TGT_CTRL);

    // a completion arriving with a clear is kept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_cnt  <= '0;
            sts_ctrl <= 1'b0;
        end else begin
            sts_cnt  <= (sts_cnt & ~clr_cnt) | set_cnt;
            sts_ctrl <= (sts_ctrl & ~clr_ctrl) | set_ctrl;
        end
    end

endmodule

// File: rtl/ftb_timebase.sv
module ftb_timebase
    import ftb_pkg::*;
#(
    parameter int unsigned APPLY_DLY = 3,
    parameter int unsigned ADDR_W    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [FTB_DW-1:0] bus_wdata,
    output logic [FTB_DW-1:0] bus_rdata
);

    localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(OFS_CNT_LO);
    localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(OFS_CNT_HI);
    localparam logic [ADDR_W-1:0] A_CWST = ADDR_W'(OFS_CNT_WST);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_KWST = ADDR_W'(OFS_CTRL_WST);

    logic              wr_acc;
    logic              rd_acc;
    wr_rec_t           in_rec;
    wr_rec_t           app_rec;
    logic [FTB_CW-1:0] cnt_q;
    logic              run_on;
    logic [1:0]        clr_cnt;
    logic              clr_ctrl;
    logic [1:0]        sts_cnt;
    logic              sts_ctrl;

    assign wr_acc = bus_req &&  bus_we;
    assign rd_acc = bus_req && !bus_we;

    // capture of delayed writes
    always_comb begin
        in_rec      = '0;
        in_rec.data = bus_wdata;
        if (wr_acc) begin
            if (bus_addr == A_LO) begin
                in_rec.vld = 1'b1;
                in_rec.tgt = TGT_LO;
            end else if (bus_addr == A_HI) begin
                in_rec.vld = 1'b1;
                in_rec.tgt = TGT_HI;
            end else if (bus_addr == A_CTRL) begin
                in_rec.vld = 1'b1;
                in_rec.tgt = TGT_CTRL;
            end
        end
    end

    // immediate write-1-to-clear
    assign clr_cnt  = (wr_acc && (bus_addr == A_CWST)) ? bus_wdata[1:0] : 2'b00;
    assign clr_ctrl = wr_acc && (bus_addr == A_KWST) && bus_wdata[CTRL_WST_BIT];

    ftb_apply_pipe #(.DEPTH(APPLY_DLY)) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_rec  (in_rec),
        .out_rec (app_rec)
    );

    ftb_count_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .app_rec (app_rec),
        .count   (cnt_q),
        .running (run_on)
    );

    ftb_status u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .app_rec  (app_rec),
        .clr_cnt  (clr_cnt),
        .clr_ctrl (clr_ctrl),
        .sts_cnt  (sts_cnt),
        .sts_ctrl (sts_ctrl)
    );

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (rd_acc) begin
            case (bus_addr)
                A_LO:    bus_rdata = cnt_q[FTB_DW-1:0];
                A_HI:    bus_rdata = cnt_q[FTB_CW-1:FTB_DW];
                A_CWST:  bus_rdata = {{(FTB_DW-2){1'b0}}, sts_cnt};
                A_CTRL:  bus_rdata[RUN_BIT] = run_on;
                A_KWST:  bus_rdata[CTRL_WST_BIT] = sts_ctrl;
                default: bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/ftb_checker.sv
module ftb_checker
    import ftb_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [FTB_DW-1:0] bus_rdata,
    input wr_rec_t           app_rec,
    input logic [FTB_CW-1:0] cnt_q,
    input logic              run_on,
    input logic [1:0]        clr_cnt,
    input logic [1:0]        sts_cnt
);

    logic app_pre;
    logic app_lo;
    logic unmapped;

    assign app_lo   = app_rec.vld && (app_rec.tgt == TGT_LO);
    assign app_pre  = app_rec.vld && (app_rec.tgt != TGT_CTRL);
    assign unmapped = (bus_addr != ADDR_W'(OFS_CNT_LO))  && (bus_addr != ADDR_W'(OFS_CNT_HI)) &&
                      (bus_addr != ADDR_W'(OFS_CNT_WST)) && (bus_addr != ADDR_W'(OFS_CTRL)) &&
                      (bus_addr != ADDR_W'(OFS_CTRL_WST));

    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_on && tick_en && !app_pre |=> cnt_q == $past(cnt_q) + 1'b1);

    // R5
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_on && !app_pre |=> $stable(cnt_q));

    // R7
    preload_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        app_lo |=> (cnt_q[FTB_DW-1:0] == $past(app_rec.data)) &&
                   (cnt_q[FTB_CW-1:FTB_DW] == $past(cnt_q[FTB_CW-1:FTB_DW])));

    // R4
    run_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        app_rec.vld && (app_rec.tgt == TGT_CTRL) |=> run_on == $past(app_rec.data[RUN_BIT]));

    // R8
    wst_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        app_lo |=> sts_cnt[0]);

    // R9
    wst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sts_cnt[0] && !clr_cnt[0] |=> sts_cnt[0]);

    // R9
    wst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cnt[0] && !app_lo |=> !sts_cnt[0]);

    // R2
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_we && unmapped |-> bus_rdata == '0);

endmodule

bind ftb_timebase ftb_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .app_rec   (app_rec),
    .cnt_q     (cnt_q),
    .run_on    (run_on),
    .clr_cnt   (clr_cnt),
    .sts_cnt   (sts_cnt)
);

// File: tb/test_ftb_timebase.sv
`timescale 1ns/1ps
module test_ftb_timebase;

    localparam int DLY = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    int tick_mode = 0; // 0 off, 1 always, 2 pseudo-random

    always #4 clk = ~clk;

    ftb_timebase #(.APPLY_DLY(DLY)) i_ftb_timebase (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_req(bus_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // ---------------- behavioural reference ----------------
    logic [63:0] m_cnt;
    logic        m_run;
    logic [1:0]  m_wst;
    logic        m_kst;
    int          cyc;
    int          q_due[$];
    int          q_tgt[$];
    logic [31:0] q_dat[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = '0; m_run = 0; m_wst = '0; m_kst = 0; cyc = 0;
            q_due.delete(); q_tgt.delete(); q_dat.delete();
        end else begin
            logic [63:0] nc;
            bit pre, set_lo, set_hi, set_k, nrun;
            nc = m_cnt; pre = 0; set_lo = 0; set_hi = 0; set_k = 0; nrun = m_run;
            if (q_due.size() > 0 && q_due[0] == cyc) begin
                int tg;
                logic [31:0] d;
                tg = q_tgt.pop_front();
                d  = q_dat.pop_front();
                void'(q_due.pop_front());
                if (tg == 0) begin nc[31:0] = d; pre = 1; set_lo = 1; end
                else if (tg == 1) begin nc[63:32] = d; pre = 1; set_hi = 1; end
                else begin nrun = d[8]; set_k = 1; end
            end
            if (!pre && m_run && tick_en) nc = m_cnt + 64'd1;
            if (bus_req && bus_we && bus_addr == 12'h110) m_wst = m_wst & ~bus_wdata[1:0];
            if (bus_req && bus_we && bus_addr == 12'h24C && bus_wdata[16]) m_kst = 0;
            if (set_lo) m_wst[0] = 1;
            if (set_hi) m_wst[1] = 1;
            if (set_k)  m_kst = 1;
            if (bus_req && bus_we) begin
                int t;
                t = -1;
                if (bus_addr == 12'h100) t = 0;
                else if (bus_addr == 12'h104) t = 1;
                else if (bus_addr == 12'h240) t = 2;
                if (t >= 0) begin
                    q_due.push_back(cyc + DLY); q_tgt.push_back(t); q_dat.push_back(bus_wdata);
                end
            end
            m_cnt = nc; m_run = nrun; cyc++;
        end
    end

    function automatic logic [31:0] mdl_read(logic [11:0] a);
        case (a)
            12'h100: return m_cnt[31:0];
            12'h104: return m_cnt[63:32];
            12'h110: return {30'd0, m_wst};
            12'h240: return {23'd0, m_run, 8'd0};
            12'h24C: return {15'd0, m_kst, 16'd0};
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            logic [31:0] e;
            string rq;
            e = (bus_req && !bus_we) ? mdl_read(bus_addr) : 32'd0;
            case (bus_addr)
                12'h100, 12'h104: rq = "R5 count";
                12'h110, 12'h24C: rq = "R8 status";
                12'h240:          rq = "R4 run";
                default:          rq = "R2 unmapped";
            endcase
            if (!(bus_req && !bus_we)) rq = "R2 idle";
            chk(bus_rdata == e, rq, {32'd0, bus_rdata}, {32'd0, e});
        end
    end

    // tick generator
    always @(negedge clk) begin
        if (tick_mode == 1) tick_en <= 1'b1;
        else if (tick_mode == 2) tick_en <= $urandom_range(0, 1);
        else tick_en <= 1'b0;
    end

    // ---------------- bus tasks (entered just after a negedge) ----------------
    int rot = 0;
    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            logic [11:0] as [5] = '{12'h100, 12'h104, 12'h110, 12'h240, 12'h24C};
            bus_req = 1; bus_we = 0; bus_addr = as[rot % 5]; rot++;
            @(negedge clk);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 0; bus_req = 0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] v, output logic [63:0] snap);
        bus_req = 1; bus_we = 0; bus_addr = a;
        #2; v = bus_rdata; snap = m_cnt;
        @(negedge clk);
    endtask

    // watchdog
    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, h0, h1, lo;
        logic [63:0] s;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset values
        begin
            logic [11:0] as [5] = '{12'h100, 12'h104, 12'h110, 12'h240, 12'h24C};
            foreach (as[i]) begin
                rd(as[i], v, s);
                chk(v == 32'd0, "R1 reset value", {32'd0, v}, 64'd0);
            end
        end

        // R10: unmapped writes have no effect
        wr(12'h108, 32'hFFFF_FFFF);
        wr(12'h24C, 32'h0);
        idle(DLY + 2);
        rd(12'h108, v, s);
        chk(v == 32'd0, "R10 unmapped read", {32'd0, v}, 64'd0);
        rd(12'h110, v, s);
        chk(v == 32'd0, "R10 status untouched", {32'd0, v}, 64'd0);
        rd(12'h100, v, s);
        chk(v == 32'd0, "R10 count untouched", {32'd0, v}, 64'd0);

        // R3: delayed low preload, only visible after DLY edges
        tick_mode = 1;
        wr(12'h100, 32'h1234_5678);
        rd(12'h100, v, s);
        chk(v == 32'd0, "R3 not yet applied", {32'd0, v}, 64'd0);
        idle(DLY);
        rd(12'h100, v, s);
        chk(v == 32'h1234_5678, "R3 low preload", {32'd0, v}, 64'h1234_5678);
        rd(12'h110, v, s);
        chk(v == 32'd1, "R8 low status bit", {32'd0, v}, 64'd1);

        // R9: write 0 keeps, write 1 clears
        wr(12'h110, 32'h0);
        rd(12'h110, v, s);
        chk(v == 32'd1, "R9 write 0 no effect", {32'd0, v}, 64'd1);
        wr(12'h110, 32'h1);
        rd(12'h110, v, s);
        chk(v == 32'd0, "R9 W1C clears", {32'd0, v}, 64'd0);

        // R4: control with other bits set, bit 8 clear: stays halted
        wr(12'h240, 32'hFFFF_FEFF);
        idle(DLY + 3);
        rd(12'h240, v, s);
        chk(v == 32'd0, "R4 stays halted", {32'd0, v}, 64'd0);
        rd(12'h24C, v, s);
        chk(v == 32'h0001_0000, "R8 ctrl status bit", {32'd0, v}, 64'h0001_0000);
        wr(12'h24C, 32'h0001_0000);
        rd(12'h100, v, s);
        chk(v == 32'h1234_5678, "R5 halted holds", {32'd0, v}, 64'h1234_5678);

        // R4/R5: start with random ticks
        tick_mode = 2;
        wr(12'h240, 32'h100);
        idle(60);
        rd(12'h240, v, s);
        chk(v == 32'h100, "R4 running", {32'd0, v}, 64'h100);

        // R11: back-to-back writes; R7: preload while running with ticks high
        tick_mode = 1;
        wr(12'h104, 32'hFFFF_FFFF);
        wr(12'h100, 32'hFFFF_FFF0);
        wr(12'h110, 32'h3);
        idle(DLY);
        rd(12'h110, v, s);
        chk(v == 32'h3, "R11 both status bits", {32'd0, v}, 64'h3);

        // R6: wrap through all ones
        idle(20);
        rd(12'h104, v, s);
        chk(v == 32'd0, "R6 wrapped upper", {32'd0, v}, 64'd0);

        // R9: set and clear on the same edge -> set wins
        wr(12'h100, 32'hAAAA_0000);
        idle(DLY - 1);
        wr(12'h110, 32'h1);
        rd(12'h110, v, s);
        chk(v[0] == 1'b1, "R9 set beats clear", {32'd0, v}, 64'd1);

        // R12: coherent split reads across low-half carries
        wr(12'h104, 32'h0000_0007);
        wr(12'h100, 32'hFFFF_FFF8);
        idle(DLY);
        for (int k = 0; k < 12; k++) begin
            int tries;
            tries = 0;
            rd(12'h104, h1, s);
            do begin
                h0 = h1;
                rd(12'h100, lo, s);
                rd(12'h104, h1, v);
                tries++;
            end while (h0 != h1 && tries < 4);
            chk(h0 == h1 && {h1, lo} == s, "R12 coherent read", {h1, lo}, s);
        end

        // R4: stop
        wr(12'h240, 32'h0);
        idle(DLY + 1);
        rd(12'h100, v, s);
        idle(10);
        rd(12'h100, h0, s);
        chk(h0 == v, "R4 stopped holds", {32'd0, h0}, {32'd0, v});

        tick_mode = 0;
        bus_req = 0;
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule